// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block sits between a processor that issues single-word loads and stores and a memory that stores whole lines at once and returns fill data one word per beat. Each byte address is split into a byte field, a word-in-line field, a line index and a tag. The index selects one line frame. One compare of the stored tag against the address tag, gated by the frame's valid bit, decides hit or miss.

Stores that hit change only the cached copy and mark the frame dirty. A dirty frame is copied back to memory as a complete line, in one wide transfer, before a different line is loaded into it. Clean frames are simply overwritten. Misses fetch the full line. The memory returns the line starting at the requested word and wrapping around. The requested word is handed to the processor as soon as its beat arrives, while the rest of the line keeps streaming in. Stores that miss allocate the line first and then merge the store into it.

The processor holds `cpu_req` and its operands stable until `cpu_ready` is high at a clock edge. A read's data is valid on `cpu_rdata` in that same cycle.

Top module: `cwb_cache`

## Requirements
- R1: The byte address is split as follows, from the low end upward. Bits [1:0] are the byte, bits [4:2] are the word in an 8-word (32-byte) line, the next log2(LINES) bits are the line index, and the remaining upper bits are the tag. Two addresses with the same index and different tags compete for the same frame.
- R2: After reset no frame is valid, `cpu_ready`, `mem_rd_req` and `mem_wr_req` are low, and the first access to any line misses.
- R3: A read that hits raises `cpu_ready` in the cycle of the request, with the cached word on `cpu_rdata`, and causes no memory traffic.
- R4: A miss raises `mem_rd_req` for exactly one cycle, with `mem_rd_addr` set to the word-aligned address of the requested word. The memory then delivers the 8 words of the line in wrapping order starting at that word. All 8 words are stored, and later reads of the line hit.
- R5: On a miss, the requested word is forwarded and `cpu_ready` is raised in the cycle its beat arrives. This beat is the first of the line, and it arrives before the remaining beats.
- R6: While a fill is in progress, a request to the line being filled is served in two cases. It is served from the cache when its word is already stored and no beat arrives that cycle. It is forwarded when its word's beat arrives. Otherwise it stalls. A request to any other line stalls until the fill has completed.
- R7: A store that hits updates only the cache, raises `cpu_ready` in the request cycle, causes no memory traffic, and marks the frame dirty.
- R8: Store size is coded on `cpu_size` as 0 = byte, 1 = half-word, 2 = word. A byte store writes lane `addr[1:0]`. A half-word store writes lanes 1:0 when `addr[1]` is 0 and lanes 3:2 when it is 1. These lanes form active-low byte enables, and only enabled bytes change.
- R9: Replacing a dirty frame first writes the whole old line to memory. `mem_wr_addr` is the old line's aligned address, and word w of the line sits at `mem_wr_data[32w+31:32w]`. The request is held until `mem_wr_ack` is high, and only then is the new line requested.
- R10: Replacing a clean frame issues no write-back.
- R11: A store that misses allocates the line. The store is merged into the requested word as it arrives, `cpu_ready` rises in that cycle, and the frame is left dirty, so that its later eviction writes it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_size | input | 2 | Store size: 0 byte, 1 half-word, 2 word |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 32 | Store data, already placed in its byte lanes |
| cpu_ready | output | 1 | Access completes at this clock edge |
| cpu_rdata | output | 32 | Load data, valid with cpu_ready |
| mem_wr_req | output | 1 | Line write-back request, held until ack |
| mem_wr_addr | output | ADDR_W | Line-aligned write-back address |
| mem_wr_data | output | 32*WORDS | Whole line, word w at bits 32w+31:32w |
| mem_wr_ack | input | 1 | Write-back accepted |
| mem_rd_req | output | 1 | One-cycle fill request |
| mem_rd_addr | output | ADDR_W | Word-aligned address of the requested word |
| mem_rd_valid | input | 1 | Fill beat present |
| mem_rd_data | input | 32 | Fill beat data, in wrapping word order |

## Verification
Hits, both loads and stores, complete in the request cycle, so the bench samples `cpu_ready` and `cpu_rdata` one time unit after the falling edge that launched the request. Forwarded words are due in the cycle of their beat, and words served during a fill are due in the first beat-free cycle after their beat. The bench therefore records, at the moment of ready, how many beats the memory model had already delivered and whether a beat was present in that cycle, and compares these against the counts each requirement predicts. Write-backs are checked after the access that caused them, by comparing the memory model's line against the shadow copy of all processor stores.

// File: rtl/cwb_pkg.sv
package cwb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WBACK,
    ST_FREQ,
    ST_FILL
  } cwb_state_e;

  // Active-low lane enables from access size and the two low address bits.
  function automatic logic [3:0] lane_en_n(input logic [1:0] size, input logic [1:0] lo);
    logic [3:0] en;
    case (size)
      2'd0:    en = 4'b0001 << lo;
      2'd1:    en = lo[1] ? 4'b1100 : 4'b0011;
      default: en = 4'b1111;
    endcase
    return ~en;
  endfunction

endpackage

// File: rtl/cwb_tag_store.sv
module cwb_tag_store #(
  parameter int LINES = 16,
  parameter int TAG_W = 3,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] look_idx,
  output logic [TAG_W-1:0] look_tag,
  output logic             look_valid,
  output logic             look_dirty,
  input  logic             alloc,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic             set_dirty,
  input  logic             set_clean,
  input  logic             set_valid,
  input  logic [IDX_W-1:0] valid_idx
);

  logic [TAG_W-1:0] tag_q [LINES];
  logic [LINES-1:0] vld_q;
  logic [LINES-1:0] drt_q;

  assign look_tag   = tag_q[look_idx];
  assign look_valid = vld_q[look_idx];
  assign look_dirty = drt_q[look_idx];

  always_ff @(posedge clk) begin
    if (alloc) tag_q[look_idx] <= alloc_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      if (alloc)     vld_q[look_idx]  <= 1'b0;
      if (set_valid) vld_q[valid_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drt_q <= '0;
    end else begin
      if (alloc || set_clean) drt_q[look_idx] <= 1'b0;
      else if (set_dirty)     drt_q[look_idx] <= 1'b1;
    end
  end

  // R4: a frame becomes valid once per fill, never while already valid
  a_r4_valid_once: assert property (@(posedge clk) disable iff (!rst_n)
    set_valid |-> !vld_q[valid_idx]);

endmodule

// File: rtl/cwb_data_store.sv
module cwb_data_store #(
  parameter int LINES = 16,
  parameter int WORDS = 8,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFF_W = $clog2(WORDS),
  localparam int DW    = 32
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [OFF_W-1:0]  rd_word,
  output logic [DW-1:0]     rd_data,
  output logic [DW*WORDS-1:0] line_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [OFF_W-1:0]  wr_word,
  input  logic [DW-1:0]     wr_data,
  input  logic [3:0]        wr_be_n
);

  logic [DW-1:0] ram_q [LINES*WORDS];

  assign rd_data = ram_q[{rd_idx, rd_word}];

  for (genvar w = 0; w < WORDS; w++) begin : g_line
    assign line_data[DW*w +: DW] = ram_q[{rd_idx, OFF_W'(w)}];
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < 4; b++) begin
        if (!wr_be_n[b]) ram_q[{wr_idx, wr_word}][8*b +: 8] <= wr_data[8*b +: 8];
      end
    end
  end

endmodule

// File: rtl/cwb_ctrl.sv
module cwb_ctrl
  import cwb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LINES  = 16,
  parameter int WORDS  = 8,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFF_W = $clog2(WORDS),
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W - 2,
  localparam int DW    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [1:0]        cpu_size,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  output logic              cpu_ready,
  output logic [DW-1:0]     cpu_rdata,
  input  logic [TAG_W-1:0]  look_tag,
  input  logic              look_valid,
  input  logic              look_dirty,
  input  logic [DW-1:0]     look_word,
  output logic              alloc,
  output logic              mark_dirty,
  output logic              mark_clean,
  output logic              mark_valid,
  output logic [IDX_W-1:0]  fill_idx_o,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [OFF_W-1:0]  wr_word,
  output logic [DW-1:0]     wr_data,
  output logic [3:0]        wr_be_n,
  output logic              mem_wr_req,
  input  logic              mem_wr_ack,
  output logic              mem_rd_req,
  input  logic              mem_rd_valid,
  input  logic [DW-1:0]     mem_rd_data
);

  cwb_state_e state_q, state_d;

  logic [IDX_W-1:0] fill_idx_q;
  logic [TAG_W-1:0] fill_tag_q;
  logic [OFF_W-1:0] fill_start_q, fill_cnt_q;
  logic [WORDS-1:0] filled_q;

  logic [IDX_W-1:0] cpu_idx;
  logic [TAG_W-1:0] cpu_tag;
  logic [OFF_W-1:0] cpu_word, beat_word;
  logic [3:0]       be_n;
  logic [DW-1:0]    merged;
  logic hit, in_fill, same_line, last_beat, idle_hit, fwd, from_buf, load_fill;

  assign cpu_word = cpu_addr[OFF_W+1:2];
  assign cpu_idx  = cpu_addr[IDX_W+OFF_W+1:OFF_W+2];
  assign cpu_tag  = cpu_addr[ADDR_W-1:IDX_W+OFF_W+2];
  assign be_n     = lane_en_n(cpu_size, cpu_addr[1:0]);

  assign hit       = look_valid && (look_tag == cpu_tag);
  assign in_fill   = (state_q == ST_FILL);
  assign same_line = (cpu_idx == fill_idx_q) && (cpu_tag == fill_tag_q);
  assign beat_word = fill_start_q + fill_cnt_q;
  assign last_beat = in_fill && mem_rd_valid && (fill_cnt_q == OFF_W'(WORDS-1));
  assign load_fill = (state_q == ST_FREQ);

  assign idle_hit = (state_q == ST_IDLE) && cpu_req && hit;
  assign fwd      = in_fill && cpu_req && same_line && mem_rd_valid && (beat_word == cpu_word);
  assign from_buf = in_fill && cpu_req && same_line && !mem_rd_valid && filled_q[cpu_word];

  assign cpu_ready = idle_hit || fwd || from_buf;
  assign cpu_rdata = fwd ? mem_rd_data : look_word;

  for (genvar b = 0; b < 4; b++) begin : g_merge
    assign merged[8*b +: 8] = be_n[b] ? mem_rd_data[8*b +: 8] : cpu_wdata[8*b +: 8];
  end

  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = cpu_idx;
    wr_word = cpu_word;
    wr_data = cpu_wdata;
    wr_be_n = be_n;
    if (in_fill && mem_rd_valid) begin
      wr_en   = 1'b1;
      wr_idx  = fill_idx_q;
      wr_word = beat_word;
      wr_data = (fwd && cpu_we) ? merged : mem_rd_data;
      wr_be_n = 4'b0000;
    end else if ((idle_hit || from_buf) && cpu_we) begin
      wr_en = 1'b1;
    end
  end

  assign alloc      = load_fill;
  assign mark_dirty = cpu_ready && cpu_we;
  assign mark_clean = (state_q == ST_WBACK) && mem_wr_ack;
  assign mark_valid = last_beat;
  assign fill_idx_o = fill_idx_q;
  assign mem_wr_req = (state_q == ST_WBACK);
  assign mem_rd_req = load_fill;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (cpu_req && !hit) state_d = (look_valid && look_dirty) ? ST_WBACK : ST_FREQ;
      ST_WBACK: if (mem_wr_ack) state_d = ST_FREQ;
      ST_FREQ:  state_d = ST_FILL;
      ST_FILL:  if (last_beat) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (load_fill) begin
      fill_idx_q   <= cpu_idx;
      fill_tag_q   <= cpu_tag;
      fill_start_q <= cpu_word;
    end
  end

  always_ff @(posedge clk) begin
    if (load_fill) begin
      fill_cnt_q <= '0;
      filled_q   <= '0;
    end else if (in_fill && mem_rd_valid) begin
      fill_cnt_q           <= fill_cnt_q + 1'b1;
      filled_q[beat_word]  <= 1'b1;
    end
  end

  // R3: completion only for a pending request
  a_r3_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_req);
  // R4: fill request lasts one cycle
  a_r4_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |=> !mem_rd_req);
  // R9: write-back held until accepted
  a_r9_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && !mem_wr_ack) |=> (mem_wr_req && $stable(cpu_addr)));
  // R6: during a fill a word is only served once its data exists
  a_r6_no_early_serve: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && in_fill) |-> (mem_rd_valid || filled_q[cpu_word]));

endmodule

// File: rtl/cwb_cache.sv
module cwb_cache #(
  parameter int ADDR_W = 12,
  parameter int LINES  = 16,
  parameter int WORDS  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_req,
  input  logic                cpu_we,
  input  logic [1:0]          cpu_size,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [31:0]         cpu_wdata,
  output logic                cpu_ready,
  output logic [31:0]         cpu_rdata,
  output logic                mem_wr_req,
  output logic [ADDR_W-1:0]   mem_wr_addr,
  output logic [32*WORDS-1:0] mem_wr_data,
  input  logic                mem_wr_ack,
  output logic                mem_rd_req,
  output logic [ADDR_W-1:0]   mem_rd_addr,
  input  logic                mem_rd_valid,
  input  logic [31:0]         mem_rd_data
);

  localparam int IDX_W = $clog2(LINES);
  localparam int OFF_W = $clog2(WORDS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W - 2;

  logic [IDX_W-1:0] cpu_idx, fill_idx, wr_idx;
  logic [OFF_W-1:0] wr_word;
  logic [TAG_W-1:0] look_tag;
  logic             look_valid, look_dirty;
  logic [31:0]      look_word, wr_data;
  logic [3:0]       wr_be_n;
  logic alloc, mark_dirty, mark_clean, mark_valid, wr_en;

  assign cpu_idx     = cpu_addr[IDX_W+OFF_W+1:OFF_W+2];
  assign mem_rd_addr = {cpu_addr[ADDR_W-1:2], 2'b00};
  assign mem_wr_addr = {look_tag, cpu_idx, {(OFF_W+2){1'b0}}};

  cwb_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk, .rst_n,
    .look_idx (cpu_idx),
    .look_tag, .look_valid, .look_dirty,
    .alloc,
    .alloc_tag(cpu_addr[ADDR_W-1:IDX_W+OFF_W+2]),
    .set_dirty(mark_dirty),
    .set_clean(mark_clean),
    .set_valid(mark_valid),
    .valid_idx(fill_idx)
  );

  cwb_data_store #(.LINES(LINES), .WORDS(WORDS)) u_data (
    .clk,
    .rd_idx   (cpu_idx),
    .rd_word  (cpu_addr[OFF_W+1:2]),
    .rd_data  (look_word),
    .line_data(mem_wr_data),
    .wr_en, .wr_idx, .wr_word, .wr_data, .wr_be_n
  );

  cwb_ctrl #(.ADDR_W(ADDR_W), .LINES(LINES), .WORDS(WORDS)) u_ctrl (
    .clk, .rst_n,
    .cpu_req, .cpu_we, .cpu_size, .cpu_addr, .cpu_wdata, .cpu_ready, .cpu_rdata,
    .look_tag, .look_valid, .look_dirty, .look_word,
    .alloc, .mark_dirty, .mark_clean, .mark_valid,
    .fill_idx_o(fill_idx),
    .wr_en, .wr_idx, .wr_word, .wr_data, .wr_be_n,
    .mem_wr_req, .mem_wr_ack, .mem_rd_req, .mem_rd_valid, .mem_rd_data
  );

  // R9: a new line is never requested over a frame still holding dirty data
  a_r9_no_fill_over_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> !(look_valid && look_dirty));
  // R2: nothing leaves the block while in reset
  a_r2_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |-> (!mem_rd_req && !mem_wr_req));

endmodule

// File: tb/cwb_cache_test.sv
`timescale 1ns/1ps
module cwb_cache_test;

  localparam int AW = 12;
  localparam int WORDS = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic cpu_req, cpu_we;
  logic [1:0] cpu_size;
  logic [AW-1:0] cpu_addr;
  logic [31:0] cpu_wdata, cpu_rdata;
  logic cpu_ready;
  logic mem_wr_req, mem_wr_ack;
  logic [AW-1:0] mem_wr_addr, mem_rd_addr;
  logic [32*WORDS-1:0] mem_wr_data;
  logic mem_rd_req, mem_rd_valid;
  logic [31:0] mem_rd_data;

  always #2.5 clk = ~clk;

  cwb_cache #(.ADDR_W(AW), .LINES(16), .WORDS(WORDS)) uut (.*);

  logic [31:0] mem_a [1024];
  logic [31:0] shadow [1024];

  int checks = 0, errors = 0;
  int n_fill = 0, n_beats = 0, n_wb = 0;
  logic [AW-1:0] last_fill_addr, last_wb_addr;
  bit done = 0;

  // memory model state
  logic       rd_act;
  logic [9:0] rd_wa;
  int         rd_n, rd_wait, gap_left;
  int         gap_at = 8, gap_len = 0;
  int         wr_wait;

  always @(posedge clk) begin
    mem_rd_valid <= 1'b0;
    if (!rst_n) begin
      rd_act <= 1'b0; mem_wr_ack <= 1'b0; wr_wait <= 0;
    end else begin
      if (mem_rd_req) begin
        rd_act <= 1'b1; rd_wa <= mem_rd_addr[AW-1:2]; rd_n <= 0; rd_wait <= 2; gap_left <= gap_len;
      end else if (rd_act) begin
        if (rd_wait != 0) rd_wait <= rd_wait - 1;
        else if (rd_n == gap_at && gap_left != 0) gap_left <= gap_left - 1;
        else begin
          mem_rd_valid <= 1'b1;
          mem_rd_data  <= mem_a[{rd_wa[9:3], rd_wa[2:0] + 3'(rd_n)}];
          rd_n <= rd_n + 1;
          if (rd_n == 7) rd_act <= 1'b0;
        end
      end
      mem_wr_ack <= 1'b0;
      if (mem_wr_req && !mem_wr_ack) begin
        if (wr_wait == 3) begin
          for (int w = 0; w < WORDS; w++) mem_a[{mem_wr_addr[AW-1:5], 3'(w)}] <= mem_wr_data[32*w +: 32];
          mem_wr_ack <= 1'b1; wr_wait <= 0;
        end else wr_wait <= wr_wait + 1;
      end
    end
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (mem_rd_req) begin n_fill <= n_fill + 1; last_fill_addr <= mem_rd_addr; end
      if (mem_rd_valid) n_beats <= n_beats + 1;
      if (mem_wr_req && mem_wr_ack) begin n_wb <= n_wb + 1; last_wb_addr <= mem_wr_addr; end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lane_mask(input logic [1:0] sz, input logic [1:0] lo);
    logic [31:0] m;
    if (sz == 2'd0)      m = 32'hFF << (8 * lo);
    else if (sz == 2'd1) m = lo[1] ? 32'hFFFF_0000 : 32'h0000_FFFF;
    else                 m = 32'hFFFF_FFFF;
    return m;
  endfunction

  task automatic access(input logic we, input logic [1:0] sz, input logic [AW-1:0] a,
                        input logic [31:0] wd, output logic [31:0] rd, output int waited,
                        output int beats_at, output logic beat_now);
    logic [31:0] m;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_size = sz; cpu_addr = a; cpu_wdata = wd; waited = 0;
    #1;
    while (!cpu_ready) begin @(negedge clk); #1; waited++; end
    rd = cpu_rdata; beats_at = n_beats; beat_now = mem_rd_valid;
    if (we) begin
      m = lane_mask(sz, a[1:0]);
      shadow[a[AW-1:2]] = (shadow[a[AW-1:2]] & ~m) | (wd & m);
    end
    @(posedge clk); #1;
    cpu_req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    #1;
    chk(!cpu_ready && !mem_rd_req && !mem_wr_req, "R2 reset outputs low",
        {29'd0, cpu_ready, mem_rd_req, mem_wr_req}, 32'd0);
  endtask

  task automatic t_cold_miss;
    logic [31:0] rd; int wt, b0, f0, ba; logic bn;
    b0 = n_beats; f0 = n_fill;
    access(0, 2, 12'h034, 0, rd, wt, ba, bn);
    chk(rd == shadow[12'h034 >> 2], "R2 first read data", rd, shadow[12'h034 >> 2]);
    chk(n_fill == f0 + 1, "R2 first access misses", n_fill, f0 + 1);
    chk(last_fill_addr == 12'h034, "R4 fill address word aligned", 32'(last_fill_addr), 32'h034);
    chk(ba == b0 && bn, "R5 critical word on first beat", ba - b0, 0);
    idle(12);
    chk(n_beats == b0 + 8, "R4 eight beats per line", n_beats - b0, 8);
    for (int w = 0; w < 8; w++) begin
      access(0, 2, 12'h020 + 12'(4*w), 0, rd, wt, ba, bn);
      chk(rd == shadow[(12'h020 >> 2) + w], "R4 stored word after wrap", rd, shadow[(12'h020 >> 2) + w]);
      chk(wt == 0, "R3 read hit same cycle", wt, 0);
    end
    chk(n_fill == f0 + 1, "R3 hits cause no fill", n_fill, f0 + 1);
  endtask

  task automatic t_fill_overlap;
    logic [31:0] rd; int wt, b0, ba; logic bn;
    b0 = n_beats;
    access(0, 2, 12'h054, 0, rd, wt, ba, bn);                 // line B word 5
    chk(rd == shadow[12'h054 >> 2], "R5 forwarded data", rd, shadow[12'h054 >> 2]);
    access(0, 2, 12'h05C, 0, rd, wt, ba, bn);                 // word 7, beat 2
    chk(rd == shadow[12'h05C >> 2] && bn, "R6 forwarded later word", rd, shadow[12'h05C >> 2]);
    access(0, 2, 12'h050, 0, rd, wt, ba, bn);                 // word 4, last beat
    chk(ba - b0 == 7 && bn, "R6 stall until last beat", ba - b0, 7);
    chk(rd == shadow[12'h050 >> 2], "R6 last word data", rd, shadow[12'h050 >> 2]);
    idle(4);
    b0 = n_beats;
    access(0, 2, 12'h060, 0, rd, wt, ba, bn);                 // line C
    access(0, 2, 12'h088, 0, rd, wt, ba, bn);                 // line D, other index
    chk(ba - b0 == 8, "R6 other line waits for fill end", ba - b0, 8);
    chk(rd == shadow[12'h088 >> 2], "R6 other line data", rd, shadow[12'h088 >> 2]);
    idle(12);
    gap_at = 4; gap_len = 5;
    b0 = n_beats;
    access(0, 2, 12'h0A0, 0, rd, wt, ba, bn);                 // line E word 0
    access(0, 2, 12'h0A0, 0, rd, wt, ba, bn);                 // already stored
    chk(!bn && ba - b0 == 4, "R6 served from stored word in beat gap", ba - b0, 4);
    chk(rd == shadow[12'h0A0 >> 2], "R6 stored word data", rd, shadow[12'h0A0 >> 2]);
    idle(20);
    gap_at = 8; gap_len = 0;
  endtask

  task automatic t_write_hit;
    logic [31:0] rd; int wt, f0, w0, ba; logic bn;
    f0 = n_fill; w0 = n_wb;
    access(1, 2, 12'h028, 32'hCAFE_F00D, rd, wt, ba, bn);
    chk(wt == 0, "R7 write hit same cycle", wt, 0);
    chk(n_fill == f0 && n_wb == w0, "R7 no memory traffic", n_fill - f0 + n_wb - w0, 0);
    access(1, 0, 12'h029, 32'h0000_5A00, rd, wt, ba, bn);    // byte lane 1
    access(1, 1, 12'h02E, 32'h1234_0000, rd, wt, ba, bn);    // upper half of word 3
    access(0, 2, 12'h028, 0, rd, wt, ba, bn);
    chk(rd == 32'hCAFE_5A0D, "R8 byte store lane 1", rd, 32'hCAFE_5A0D);
    access(0, 2, 12'h02C, 0, rd, wt, ba, bn);
    chk(rd == shadow[12'h02C >> 2] && rd[31:16] == 16'h1234, "R8 half store upper lanes", rd, shadow[12'h02C >> 2]);
    chk(mem_a[12'h028 >> 2] != shadow[12'h028 >> 2], "R7 memory not updated", mem_a[12'h028 >> 2], ~shadow[12'h028 >> 2]);
  endtask

  task automatic t_dirty_evict;
    logic [31:0] rd; int wt, w0, ba; logic bn;
    w0 = n_wb;
    access(0, 2, 12'h224, 0, rd, wt, ba, bn);                 // same index as A, new tag
    chk(n_wb == w0 + 1, "R9 dirty line written back", n_wb - w0, 1);
    chk(last_wb_addr == 12'h020, "R1 R9 write-back address", 32'(last_wb_addr), 32'h020);
    for (int w = 0; w < 8; w++)
      chk(mem_a[(12'h020 >> 2) + w] == shadow[(12'h020 >> 2) + w], "R9 whole line in memory",
          mem_a[(12'h020 >> 2) + w], shadow[(12'h020 >> 2) + w]);
    chk(rd == shadow[12'h224 >> 2], "R9 new line data after write-back", rd, shadow[12'h224 >> 2]);
    idle(12);
  endtask

  task automatic t_clean_evict;
    logic [31:0] rd; int wt, w0, f0, ba; logic bn;
    w0 = n_wb; f0 = n_fill;
    access(0, 2, 12'h440, 0, rd, wt, ba, bn);                 // replaces clean line B
    chk(n_wb == w0, "R10 clean line not written back", n_wb - w0, 0);
    chk(n_fill == f0 + 1, "R10 replacement fills", n_fill - f0, 1);
    idle(12);
  endtask

  task automatic t_write_miss;
    logic [31:0] rd; int wt, w0, b0, ba; logic bn;
    logic [31:0] exp;
    w0 = n_wb; b0 = n_beats;
    exp = (shadow[12'h0CC >> 2] & 32'h0000_FFFF) | 32'hBEEF_0000;
    access(1, 1, 12'h0CE, 32'hBEEF_0000, rd, wt, ba, bn);
    chk(ba == b0 && bn, "R11 store released at critical beat", ba - b0, 0);
    chk(n_wb == w0, "R11 no write-back of invalid frame", n_wb - w0, 0);
    idle(12);
    access(0, 2, 12'h0CC, 0, rd, wt, ba, bn);
    chk(rd == exp && wt == 0, "R11 merged store", rd, exp);
    access(0, 2, 12'h2C0, 0, rd, wt, ba, bn);
    chk(n_wb == w0 + 1 && last_wb_addr == 12'h0C0, "R11 allocated line dirty", n_wb - w0, 1);
    chk(mem_a[12'h0CC >> 2] == exp, "R11 merged word written back", mem_a[12'h0CC >> 2], exp);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin
      mem_a[i]  = (32'(i) * 32'h0100_0193) ^ 32'hA5A5_3C3C;
      shadow[i] = (32'(i) * 32'h0100_0193) ^ 32'hA5A5_3C3C;
    end
    cpu_req = 0; cpu_we = 0; cpu_size = 0; cpu_addr = '0; cpu_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle(2);
    t_cold_miss();
    t_fill_overlap();
    t_write_hit();
    t_dirty_evict();
    t_clean_evict();
    t_write_miss();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule